// File: doc/BRIEF.md
# Grouped Carry Look-Ahead Adder/Subtractor

This block adds or subtracts two 16-bit operands. The word is split into four 4-bit slices. Inside a slice, every carry is formed directly from the per-bit generate term (operand bits ANDed) and propagate term (operand bits ORed) and from the slice's incoming carry, so no carry ripples bit by bit. Between slices, the carry leaving one slice becomes the carry entering the next higher one. Each sum bit is formed separately as the XOR of the two operand bits and that bit's incoming carry.

A single select input chooses between addition and subtraction. For subtraction the second operand is complemented and a 1 is injected at bit 0, so the same look-ahead hardware serves both operations. The block reports the 16-bit result, the carry out of the top slice, and a signed overflow flag. An output register, enabled by default, gives the result a fixed latency of one clock so that the timing of the adder path can be checked.

Top module: `cla_adder16`

## Requirements
- R1: A synchronous, active-high `rst` clears `sum`, `carry_out` and `overflow` to 0 at the next rising edge of `clk`.
- R2: With `sub` = 0, `sum` equals (`a` + `b` + `carry_in`) mod 65536 one clock after the inputs are sampled.
- R3: With `sub` = 0, `carry_out` equals bit 16 of `a` + `b` + `carry_in`.
- R4: With `sub` = 1, `sum` equals (`a` − `b`) mod 65536 one clock after the inputs are sampled.
- R5: With `sub` = 1, `carry_in` has no effect on any output.
- R6: With `sub` = 1, `carry_out` is 1 exactly when `a` ≥ `b` as unsigned numbers, meaning no borrow.
- R7: With `sub` = 0, `overflow` is 1 exactly when the two's-complement value of `a` + `b` + `carry_in` lies outside [−32768, 32767].
- R8: With `sub` = 1, `overflow` is 1 exactly when the two's-complement value of `a` − `b` lies outside [−32768, 32767].
- R9: A carry crosses every slice boundary. For example, `a` = 0xFFFF, `b` = 0 and `carry_in` = 1 in add mode give `sum` = 0 and `carry_out` = 1, and 0x000F + 0x0001 gives 0x0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 16 | First operand |
| b | input | 16 | Second operand (the subtrahend when subtracting) |
| carry_in | input | 1 | Carry into bit 0 in add mode |
| sub | input | 1 | 0 selects add, 1 selects subtract |
| sum | output | 16 | Registered result |
| carry_out | output | 1 | Carry out of the top slice (no-borrow when subtracting) |
| overflow | output | 1 | Two's-complement overflow |

## Verification
Directed vectors separate the cases that each carry path must handle:
- Carries that cross one slice boundary, and carries that cross all of them.
- Sign-boundary sums and differences such as 0x7FFF + 1 and 0x8000 − 1, which tell a correct overflow from one taken off the wrong carry.
- Subtractions with `a` below, equal to and above `b`, which pin down the no-borrow meaning of the carry.
- Pairs that differ only in `carry_in` while subtracting, which show that input is ignored.

Several thousand random operand pairs in both modes are then compared on every clock against an integer model. That model uses signed and unsigned range arithmetic and shares no structure with the slices. A reset in mid-run shows that the register clears regardless of the operands.

// File: rtl/cla_adder_pkg.sv
package cla_adder_pkg;

    localparam int WORD_W = 16;
    localparam int GRP_W  = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    // Per-bit generate (AND) and inclusive-OR propagate
    function automatic pg_t make_pg(input logic x, input logic y);
        pg_t r;
        r.gen  = x & y;
        r.prop = x | y;
        return r;
    endfunction

    // Sum is taken apart from the propagate term: x ^ y ^ carry
    function automatic logic sum_bit(input logic x, input logic y, input logic c);
        return (x ^ y) ^ c;
    endfunction

endpackage

// File: rtl/cla_operand_prep.sv
module cla_operand_prep
    import cla_adder_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] b_in,
    input  op_e          op,
    input  logic         c_in,
    output logic [W-1:0] b_out,
    output logic         c_out
);

    always_comb begin
        unique case (op)
            OP_SUB: begin
                b_out = ~b_in;
                c_out = 1'b1;
            end
            default: begin
                b_out = b_in;
                c_out = c_in;
            end
        endcase
    end

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_adder_pkg::*;
#(
    parameter int GW = GRP_W
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          c_in,
    output logic [GW-1:0] s,
    output logic [GW:0]   c
);

    pg_t pg [GW];

    always_comb begin
        for (int i = 0; i < GW; i++) begin
            pg[i] = make_pg(x[i], y[i]);
        end
    end

    // Every carry k is a flat sum of products over bits below k and c_in
    always_comb begin
        logic term;
        logic prod;
        c[0] = c_in;
        for (int k = 1; k <= GW; k++) begin
            term = 1'b0;
            for (int j = 0; j < k; j++) begin
                prod = pg[j].gen;
                for (int m = j + 1; m < k; m++) begin
                    prod = prod & pg[m].prop;
                end
                term = term | prod;
            end
            prod = c_in;
            for (int m = 0; m < k; m++) begin
                prod = prod & pg[m].prop;
            end
            c[k] = term | prod;
        end
    end

    always_comb begin
        for (int i = 0; i < GW; i++) begin
            s[i] = sum_bit(x[i], y[i], c[i]);
        end
    end

endmodule

// File: rtl/cla_chain.sv
module cla_chain
    import cla_adder_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int GW = GRP_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c_in,
    output logic [W-1:0] s,
    output logic [W:0]   carries
);

    localparam int NG = W / GW;

    logic [NG:0] grp_c;

    assign grp_c[0] = c_in;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GW:0] cl;

        cla_group #(.GW(GW)) u_grp (
            .x    (x[g*GW +: GW]),
            .y    (y[g*GW +: GW]),
            .c_in (grp_c[g]),
            .s    (s[g*GW +: GW]),
            .c    (cl)
        );

        assign grp_c[g+1]          = cl[GW];
        assign carries[g*GW +: GW] = cl[GW-1:0];
    end

    assign carries[W] = grp_c[NG];

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_adder_pkg::*;
#(
    parameter int W       = WORD_W,
    parameter int GW      = GRP_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_in,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);

    typedef struct packed {
        logic [W-1:0] s;
        logic         co;
        logic         ov;
    } res_t;

    op_e          op;
    logic [W-1:0] b_eff;
    logic         c0;
    logic [W-1:0] s_raw;
    logic [W:0]   carries;
    res_t         nxt;
    res_t         q;

    assign op = op_e'(sub);

    cla_operand_prep #(.W(W)) u_prep (
        .b_in  (b),
        .op    (op),
        .c_in  (carry_in),
        .b_out (b_eff),
        .c_out (c0)
    );

    cla_chain #(.W(W), .GW(GW)) u_chain (
        .x       (a),
        .y       (b_eff),
        .c_in    (c0),
        .s       (s_raw),
        .carries (carries)
    );

    always_comb begin
        nxt.s  = s_raw;
        nxt.co = carries[W];
        nxt.ov = carries[W] ^ carries[W-1];
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        function automatic logic [W:0] ref_add(input logic [W-1:0] x,
                                               input logic [W-1:0] y,
                                               input logic         ci,
                                               input logic         sb);
            logic [W:0] yy;
            logic [W:0] cc;
            yy = sb ? {1'b0, ~y} : {1'b0, y};
            cc = {{W{1'b0}}, (sb ? 1'b1 : ci)};
            return {1'b0, x} + yy + cc;
        endfunction

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (sum == '0 && !carry_out && !overflow));

        // R2
        sum_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> sum == ref_add($past(a), $past(b), $past(carry_in), $past(sub))[W-1:0]);

        // R3
        carry_out_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> carry_out == ref_add($past(a), $past(b), $past(carry_in), $past(sub))[W]);

        // R7
        overflow_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> overflow ==
                (($past(a[W-1]) == ($past(sub) ? ~$past(b[W-1]) : $past(b[W-1])))
                 && (sum[W-1] != $past(a[W-1]))));
    end else begin : g_comb
        assign q = nxt;
    end

    // R9: look-ahead carries agree with the bit-serial recurrence
    for (genvar k = 0; k < W; k++) begin : g_cchk
        carry_ripple_chk: assert property (@(posedge clk) disable iff (rst)
            carries[k+1] == ((a[k] & b_eff[k]) | ((a[k] | b_eff[k]) & carries[k])));
    end

    assign sum       = q.s;
    assign carry_out = q.co;
    assign overflow  = q.ov;

endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        carry_in = 1'b0;
    logic        sub = 1'b0;
    logic [15:0] sum;
    logic        carry_out;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] s;
        bit          co;
        bit          ov;
        bit          sb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10ns clk = ~clk;

    cla_adder16 dut_i (
        .clk       (clk),
        .rst       (rst),
        .a         (a),
        .b         (b),
        .carry_in  (carry_in),
        .sub       (sub),
        .sum       (sum),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [15:0] x, input logic [15:0] y,
                                   input bit ci, input bit sb, input string tag);
        exp_t e;
        int unsigned xu = x;
        int unsigned yu = y;
        int xs = int'($signed(x));
        int ys = int'($signed(y));
        int sv;
        if (sb) begin
            e.s  = 16'((xu - yu) & 32'hFFFF);
            e.co = (xu >= yu);
            sv   = xs - ys;
        end else begin
            e.s  = 16'((xu + yu + ci) & 32'hFFFF);
            e.co = ((xu + yu + ci) >> 16) != 0;
            sv   = xs + ys + int'(ci);
        end
        e.ov  = (sv > 32767) || (sv < -32768);
        e.sb  = sb;
        e.tag = tag;
        return e;
    endfunction

    task automatic check_pending();
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            if (e.tag != "")
                chk(e.tag, {16'h0, sum}, {16'h0, e.s});
            else
                chk(e.sb ? "R4 sum" : "R2 sum", {16'h0, sum}, {16'h0, e.s});
            chk(e.sb ? "R6 carry_out" : "R3 carry_out", {31'h0, carry_out}, {31'h0, e.co});
            chk(e.sb ? "R8 overflow" : "R7 overflow", {31'h0, overflow}, {31'h0, e.ov});
        end
    endtask

    task automatic step(input logic [15:0] x, input logic [15:0] y,
                        input bit ci, input bit sb, input string tag);
        @(negedge clk);
        check_pending();
        a = x;
        b = y;
        carry_in = ci;
        sub = sb;
        exp_q.push_back(model(x, y, ci, sb, tag));
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sum", {16'h0, sum}, 32'h0);
        chk("R1 carry_out", {31'h0, carry_out}, 32'h0);
        chk("R1 overflow", {31'h0, overflow}, 32'h0);
        rst = 1'b0;

        step(16'h0000, 16'h0000, 1'b0, 1'b0, "");
        step(16'h1234, 16'h4321, 1'b0, 1'b0, "");
        step(16'h000F, 16'h0001, 1'b0, 1'b0, "R9 sum group boundary");
        step(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R9 sum full chain");
        step(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R9 sum three boundaries");
        step(16'h7FFF, 16'h0001, 1'b0, 1'b0, "");
        step(16'h8000, 16'h8000, 1'b0, 1'b0, "");
        step(16'h7FFF, 16'h0000, 1'b1, 1'b0, "");
        step(16'h0005, 16'h0003, 1'b0, 1'b1, "");
        step(16'h0003, 16'h0005, 1'b0, 1'b1, "");
        step(16'h1234, 16'h1234, 1'b0, 1'b1, "");
        step(16'h8000, 16'h0001, 1'b0, 1'b1, "");
        step(16'h7FFF, 16'hFFFF, 1'b0, 1'b1, "");
        // R5: carry_in ignored when subtracting
        step(16'h4000, 16'h1001, 1'b0, 1'b1, "R5 sum cin=0");
        step(16'h4000, 16'h1001, 1'b1, 1'b1, "R5 sum cin=1");
        step(16'h0000, 16'h0000, 1'b1, 1'b1, "R5 sum zero cin=1");

        for (int i = 0; i < 3000; i++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "");
        end
        flush();

        // R1: reset in mid-run clears outputs despite live operands
        @(negedge clk);
        rst = 1'b1;
        a = 16'hFFFF;
        b = 16'hFFFF;
        carry_in = 1'b1;
        sub = 1'b0;
        @(negedge clk);
        chk("R1 sum mid-run", {16'h0, sum}, 32'h0);
        chk("R1 carry_out mid-run", {31'h0, carry_out}, 32'h0);
        chk("R1 overflow mid-run", {31'h0, overflow}, 32'h0);
        rst = 1'b0;

        step(16'h8001, 16'h8001, 1'b0, 1'b0, "");
        flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule